// File: doc/BRIEF.md
# Converter Interrupt Status Register Bank

This block collects the interrupt events of a two-channel converter subsystem and presents them to software as a small word-addressed register bank. There are six event sources: a conversion-complete event, a fault event and a wake event for each of the two channels. A one-cycle pulse on an event input latches a sticky pending bit. Software retires a pending bit by writing a one to the acknowledge register.

A mask register decides which pending bits reach the masked view and the single interrupt line. Software can load the mask as a whole word, or change single bits through a set port and a clear port, which avoids read-modify-write races. Each channel also has a gate bit that stops that channel's conversion-complete event from latching at all. The interrupt line is the OR of the masked bits, registered once.

The bus port is a plain single-cycle write strobe with an address and write data. Read data is a combinational decode of the address. The asynchronous reset input is synchronised inside the block before it reaches the registers.

Top module: `irqbank_regs`

## Requirements
- R1: Pending, mask and masked-view bit positions are fixed: bit 0 ch1 complete, bit 1 ch2 complete, bit 2 ch1 fault, bit 3 ch2 fault, bit 4 ch1 wake, bit 5 ch2 wake. Bits 31..6 of every register read as zero, and unmapped address 7 reads as zero.
- R2: A one-cycle pulse on `evt_i[k]` sets pending bit k (address 0) at the next clock edge. The bit stays set until a write to address 3 has bit k at 1. Writes to address 0 have no effect.
- R3: If an event pulse and an acknowledge write hit the same pending bit in the same cycle, the bit ends up set.
- R4: The masked view (address 2) reads pending AND mask. Writes to address 2 have no effect.
- R5: A write to address 1 loads the whole mask from `wdata_i[5:0]`, and the mask reads back at address 1.
- R6: A write to address 4 sets each mask bit whose `wdata_i` bit is 1 and leaves the other mask bits unchanged.
- R7: A write to address 5 clears each mask bit whose `wdata_i` bit is 1 and leaves the other mask bits unchanged.
- R8: Addresses 3, 4 and 5 are write-trigger only and always read as zero.
- R9: After reset, pending, mask and masked view are 0, the channel gate register (address 6) is 2'b11, and `irq_o` is 0.
- R10: Address 6 holds the channel gates (bit 0 ch1, bit 1 ch2). While a channel's gate is 0, that channel's complete event does not set its pending bit. The channel's fault and wake events still set theirs.
- R11: `irq_o` equals the OR of the masked view, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses, in the bit order of R1 |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A hardware event pulse and a software acknowledge write can land on the same pending bit in the same clock. The bench provokes this by driving the event input and the acknowledge write in the same cycle. The pending bit must still read one afterwards, and an acknowledge alone in a later cycle must then clear it. The bench also gives a gate change and an event burst their own cycles, and checks which complete bits latched.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int NSRC = 6;
  localparam int NCH  = 2;

  typedef enum logic [2:0] {
    A_PEND = 3'd0,
    A_MASK = 3'd1,
    A_VIEW = 3'd2,
    A_ACK  = 3'd3,
    A_MSET = 3'd4,
    A_MCLR = 3'd5,
    A_GATE = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irqbank_rst_sync.sv
module irqbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irqbank_pending.sv
module irqbank_pending #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_d, pend_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    // Hardware set has priority over software acknowledge.
    always_comb begin
      pend_d[k] = pend_q[k];
      if (ack_i[k]) pend_d[k] = 1'b0;
      if (set_i[k]) pend_d[k] = 1'b1;
    end

    p_set_latches_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> pend_q[k]);
    p_ack_retires_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[k] && !set_i[k]) |=> !pend_q[k]);
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ack_i[k] && !set_i[k]) |=> $stable(pend_q[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqbank_mask.sv
module irqbank_mask #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_d, mask_q;
  logic         mask_en;

  assign mask_en = load_i | set_i | clr_i;

  always_comb begin
    mask_d = mask_q;
    if (load_i)     mask_d = wdata_i;
    else if (set_i) mask_d = mask_q | wdata_i;
    else if (clr_i) mask_d = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  p_set_port_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !load_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  p_set_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !load_i) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
  p_clr_port_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i && !set_i) |=> ((mask_q & $past(wdata_i)) == '0));
  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/irqbank_regs.sv
module irqbank_regs
  import irqbank_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  localparam int PAD_SRC = DW - NSRC;
  localparam int PAD_CH  = DW - NCH;

  logic            rst_n;
  logic [NSRC-1:0] pend, mask, view, evt_gate, set_vec, ack_vec;
  logic            wr_pend_ack, wr_mload, wr_mset, wr_mclr, wr_gate;
  logic [NCH-1:0]  gate_d, gate_q;
  logic            irq_d, irq_q;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:NSRC];

  irqbank_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  // Write decode
  assign wr_pend_ack = wr_en_i && (addr_i == A_ACK);
  assign wr_mload    = wr_en_i && (addr_i == A_MASK);
  assign wr_mset     = wr_en_i && (addr_i == A_MSET);
  assign wr_mclr     = wr_en_i && (addr_i == A_MCLR);
  assign wr_gate     = wr_en_i && (addr_i == A_GATE);

  // Channel gates block only the complete events (low NCH bits)
  assign evt_gate = {{(NSRC-NCH){1'b1}}, gate_q};
  assign set_vec  = evt_i & evt_gate;
  assign ack_vec  = wr_pend_ack ? wdata_i[NSRC-1:0] : '0;

  irqbank_pending #(.N(NSRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .set_i (set_vec),
    .ack_i (ack_vec),
    .pend_o(pend)
  );

  irqbank_mask #(.N(NSRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (wr_mload),
    .set_i  (wr_mset),
    .clr_i  (wr_mclr),
    .wdata_i(wdata_i[NSRC-1:0]),
    .mask_o (mask)
  );

  assign view = pend & mask;

  // Gate register
  always_comb begin
    gate_d = gate_q;
    if (wr_gate) gate_d = wdata_i[NCH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) gate_q <= '1;
    else        gate_q <= gate_d;
  end

  // Interrupt output
  assign irq_d = |view;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // Read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_PEND:  rdata_o = {{PAD_SRC{1'b0}}, pend};
      A_MASK:  rdata_o = {{PAD_SRC{1'b0}}, mask};
      A_VIEW:  rdata_o = {{PAD_SRC{1'b0}}, view};
      A_GATE:  rdata_o = {{PAD_CH{1'b0}}, gate_q};
      default: rdata_o = '0;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_gate_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!gate_q[c] && !pend[c] && !wr_en_i) |=> !pend[c]);
  end

  p_irq_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|(pend & mask)) |=> irq_o);
  p_irq_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|(pend & mask)) |=> !irq_o);
endmodule

// File: tb/irqbank_regs_test.sv
module irqbank_regs_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [5:0]  evt;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irqbank_regs uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .wr_en_i(wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); check("R9 pending after reset", d, 0);
    rd(3'd1, d); check("R9 mask after reset", d, 0);
    rd(3'd2, d); check("R9 view after reset", d, 0);
    rd(3'd6, d); check("R9 gate after reset", d, 32'h3);
    check("R9 irq after reset", {31'd0, irq}, 0);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    pulse(6'b010100);
    rd(3'd0, d); check("R2 event sets pending", d, 32'h14);
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R2 pending sticky", d, 32'h14);
    wr(3'd0, 32'h0);
    rd(3'd0, d); check("R2 write to pending ignored", d, 32'h14);
    wr(3'd0, 32'h3F);
    rd(3'd0, d); check("R2 write ones to pending ignored", d, 32'h14);
    wr(3'd3, 32'h04);
    rd(3'd0, d); check("R2 ack clears only bit 2", d, 32'h10);
    wr(3'd3, 32'h3F);
    rd(3'd0, d); check("R2 ack all", d, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk);
    evt = 6'b000001; addr = 3'd3; wdata = 32'h1; wr_en = 1'b1;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wdata = '0;
    rd(3'd0, d); check("R3 set beats ack from clear", d, 32'h1);
    @(negedge clk);
    evt = 6'b000001; addr = 3'd3; wdata = 32'h1; wr_en = 1'b1;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wdata = '0;
    rd(3'd0, d); check("R3 set beats ack while set", d, 32'h1);
    wr(3'd3, 32'h1);
    rd(3'd0, d); check("R3 ack alone clears", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FF2A);
    rd(3'd1, d); check("R5 direct mask load", d, 32'h2A);
    wr(3'd4, 32'h05);
    rd(3'd1, d); check("R6 set port", d, 32'h2F);
    wr(3'd4, 32'h0);
    rd(3'd1, d); check("R6 zeros leave mask", d, 32'h2F);
    wr(3'd5, 32'h22);
    rd(3'd1, d); check("R7 clear port", d, 32'h0D);
    wr(3'd5, 32'h0);
    rd(3'd1, d); check("R7 zeros leave mask", d, 32'h0D);
    wr(3'd1, 32'h0);
    rd(3'd1, d); check("R5 direct mask zero", d, 0);
  endtask

  task automatic t_view_irq;
    logic [31:0] d;
    wr(3'd1, 32'h15);
    pulse(6'b111111);
    rd(3'd2, d); check("R4 view is pending and mask", d, 32'h15);
    check("R11 irq one cycle after view", {31'd0, irq}, 0);
    @(negedge clk);
    check("R11 irq raised", {31'd0, irq}, 1);
    wr(3'd2, 32'h0);
    rd(3'd2, d); check("R4 write to view ignored", d, 32'h15);
    rd(3'd0, d); check("R1 all six pending bits", d, 32'h3F);
    wr(3'd1, 32'h0);
    rd(3'd2, d); check("R4 view with empty mask", d, 0);
    check("R11 irq still high one cycle", {31'd0, irq}, 1);
    @(negedge clk);
    check("R11 irq dropped", {31'd0, irq}, 0);
    wr(3'd1, 32'h20);
    @(negedge clk);
    check("R11 irq from wake ch2", {31'd0, irq}, 1);
    wr(3'd3, 32'h3F);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_trigger_reads;
    logic [31:0] d;
    rd(3'd3, d); check("R8 ack reads zero", d, 0);
    wr(3'd4, 32'h3F);
    rd(3'd4, d); check("R8 set port reads zero", d, 0);
    rd(3'd5, d); check("R8 clear port reads zero", d, 0);
    rd(3'd7, d); check("R1 unmapped reads zero", d, 0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); check("R1 gate upper bits zero", d, 32'h3);
    rd(3'd1, d); check("R1 mask upper bits zero", d, 32'h3F);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(3'd6, 32'h2);
    pulse(6'b111111);
    rd(3'd0, d); check("R10 ch1 complete gated", d, 32'h3E);
    wr(3'd3, 32'h3F);
    wr(3'd6, 32'h1);
    pulse(6'b111111);
    rd(3'd0, d); check("R10 ch2 complete gated", d, 32'h3D);
    wr(3'd3, 32'h3F);
    wr(3'd6, 32'h0);
    pulse(6'b000011);
    rd(3'd0, d); check("R10 both gated", d, 0);
    wr(3'd6, 32'h3);
    pulse(6'b000011);
    rd(3'd0, d); check("R10 gates reopened", d, 32'h3);
    wr(3'd3, 32'h3F);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; evt = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pending();
    t_set_wins();
    t_mask();
    t_view_irq();
    t_trigger_reads();
    t_gate();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule